// File: doc/BRIEF.md
# Scan-Loadable Muller C-Element Cell

This block is a single two-input Muller C-element whose stored bit can also be loaded and unloaded through a serial scan path. In functional operation the output rises once both inputs are high, falls once both are low, and otherwise keeps its value. When the shift enable is raised, the functional inputs lose all influence. A level-sensitive shift clock then moves a bit from the serial input into the cell in master/slave fashion. While the shift clock is high the master follows the serial input. When it falls, the inverse of the last master value becomes the stored state.

All storage is registered on one system clock. The shift clock and shift enable are treated as ordinary sampled levels. The serial output always shows the stored state and does not move while the shift clock is high. Chaining the serial output of one cell to the serial input of the next therefore gives a working shift register: every cell captures its neighbour's old value during the high phase, and all cells commit together on the falling level.

A small control state machine tracks the shift phase in four states. FUNC is functional mode. ARMED means shift is enabled and the cell is waiting for the shift clock. SAMPLE means the shift clock is high and the master is capturing. LOCKOUT means a shift clock pulse was already under way when shift was enabled, and the cell waits for it to end. The transitions are as follows:
- Any state goes to FUNC when the shift enable is low.
- FUNC goes to ARMED, or to LOCKOUT if the shift clock is high, when the shift enable rises.
- ARMED goes to SAMPLE when the shift clock goes high.
- SAMPLE returns to ARMED when the shift clock goes low, and that return is the commit.
- LOCKOUT goes to ARMED when the shift clock goes low, without a commit.

Top module: `muller_scan_cell`

## Requirements
- R1: A synchronous reset, active high, clears the stored state and the master. After reset, c_out and shift_out are 0 and the cell is in FUNC, even if both functional inputs are high during reset.
- R2: With shift_en low, in_a and in_b both 1 at a clock edge make c_out 1 after that edge.
- R3: With shift_en low, in_a and in_b both 0 at a clock edge make c_out 0 after that edge.
- R4: With shift_en low and in_a different from in_b, c_out keeps its value. The shift clock and shift input have no effect while shift_en is low.
- R5: With shift_en high, in_a and in_b have no effect on the stored state. c_out changes only at a commit.
- R6: At any edge where shift_en and shift_clk are both high, shift_out and c_out keep their values.
- R7: A commit is an edge in SAMPLE with shift_en high and shift_clk low. It stores the complement of shift_in as sampled at the last edge where shift_clk was high. That value then appears on both c_out and shift_out.
- R8: A shift clock pulse that was already high when shift_en rose (state LOCKOUT) commits nothing when it ends. The next full pulse commits normally.
- R9: If shift_en drops while shift_clk is high in SAMPLE, the captured bit is discarded. A later shift clock low with shift_en high does not commit it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_a | input | 1 | First functional input |
| in_b | input | 1 | Second functional input |
| shift_en | input | 1 | Scan enable, high blocks the functional path |
| shift_clk | input | 1 | Level-sensitive scan clock |
| shift_in | input | 1 | Serial scan input |
| shift_out | output | 1 | Serial scan output, equal to the stored state |
| c_out | output | 1 | C-element output, equal to the stored state |

## Verification
The cell has no parameters, so the bench builds it in its single fixed form. That one build reaches every control state and transition. It covers shift pulses that are abandoned by a falling enable and pulses that began before the enable rose. It also covers changes of shift_in during a long high phase, where only the last sample may count. A long stretch of random stimulus then mixes functional and shift activity against a scoreboard reference.

// File: rtl/mscan_pkg.sv
package mscan_pkg;

    typedef enum logic [1:0] {
        PH_FUNC    = 2'd0,
        PH_ARMED   = 2'd1,
        PH_SAMPLE  = 2'd2,
        PH_LOCKOUT = 2'd3
    } mscan_phase_e;

    // Muller rule: rise when both high, fall when both low, else hold.
    function automatic logic c_rule(input logic x, input logic y, input logic held);
        return (x & y) | (held & (x | y));
    endfunction

endpackage

// File: rtl/mscan_ctrl.sv
module mscan_ctrl
    import mscan_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         shift_clk,
    output mscan_phase_e phase_q,
    output logic         capture_en,
    output logic         commit_en
);

    mscan_phase_e phase_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FUNC;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        if (!shift_en) begin
            phase_d = PH_FUNC;
        end else begin
            unique case (phase_q)
                PH_FUNC:    phase_d = shift_clk ? PH_LOCKOUT : PH_ARMED;
                PH_ARMED:   phase_d = shift_clk ? PH_SAMPLE  : PH_ARMED;
                PH_SAMPLE:  phase_d = shift_clk ? PH_SAMPLE  : PH_ARMED;
                PH_LOCKOUT: phase_d = shift_clk ? PH_LOCKOUT : PH_ARMED;
                default:    phase_d = PH_FUNC;
            endcase
        end
    end

    always_comb begin
        capture_en = 1'b0;
        commit_en  = 1'b0;
        if (shift_en) begin
            unique case (phase_q)
                PH_ARMED:   capture_en = shift_clk;
                PH_SAMPLE: begin
                    capture_en = shift_clk;
                    commit_en  = !shift_clk;
                end
                PH_FUNC:    capture_en = 1'b0;
                PH_LOCKOUT: capture_en = 1'b0;
                default:    capture_en = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/mscan_store.sv
module mscan_store
    import mscan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    input  logic shift_en,
    input  logic shift_in,
    input  logic capture_en,
    input  logic commit_en,
    output logic state_q
);

    logic master_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            master_q <= 1'b0;
        end else if (capture_en) begin
            master_q <= shift_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
        end else if (!shift_en) begin
            state_q <= c_rule(in_a, in_b, state_q);
        end else if (commit_en) begin
            state_q <= ~master_q;
        end
    end

endmodule

// File: rtl/muller_scan_cell.sv
module muller_scan_cell
    import mscan_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_a,
    input  logic in_b,
    input  logic shift_en,
    input  logic shift_clk,
    input  logic shift_in,
    output logic shift_out,
    output logic c_out
);

    mscan_phase_e phase_w;
    logic         capture_w;
    logic         commit_w;
    logic         state_w;

    mscan_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .shift_clk  (shift_clk),
        .phase_q    (phase_w),
        .capture_en (capture_w),
        .commit_en  (commit_w)
    );

    mscan_store u_store (
        .clk        (clk),
        .rst        (rst),
        .in_a       (in_a),
        .in_b       (in_b),
        .shift_en   (shift_en),
        .shift_in   (shift_in),
        .capture_en (capture_w),
        .commit_en  (commit_w),
        .state_q    (state_w)
    );

    assign shift_out = state_w;
    assign c_out     = state_w;

endmodule

// File: rtl/mscan_cell_chk.sv
module mscan_cell_chk
    import mscan_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         in_a,
    input logic         in_b,
    input logic         shift_en,
    input logic         shift_clk,
    input logic         shift_in,
    input logic         shift_out,
    input logic         c_out,
    input mscan_phase_e phase_w
);

    p_both_high_r2: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && in_a && in_b) |=> c_out);

    p_both_low_r3: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !in_a && !in_b) |=> !c_out);

    p_mixed_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && (in_a != in_b)) |=> $stable(c_out));

    p_func_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !(phase_w == PH_SAMPLE && !shift_clk)) |=> $stable(c_out));

    p_out_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (shift_en && shift_clk) |=> $stable(shift_out));

    p_commit_inverts_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_w == PH_SAMPLE && shift_en && !shift_clk) |=> (shift_out == !$past(shift_in, 2)));

    p_lockout_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_w == PH_LOCKOUT && shift_en) |=> $stable(shift_out));

endmodule

bind muller_scan_cell mscan_cell_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_a      (in_a),
    .in_b      (in_b),
    .shift_en  (shift_en),
    .shift_clk (shift_clk),
    .shift_in  (shift_in),
    .shift_out (shift_out),
    .c_out     (c_out),
    .phase_w   (phase_w)
);

// File: tb/sim_muller_scan_cell.sv
module sim_muller_scan_cell;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_a = 1'b0, in_b = 1'b0, shift_en = 1'b0, shift_clk = 1'b0, shift_in = 1'b0;
    logic shift_out, c_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit    exp_q[$];
    string tag_q[$];

    // reference model state, phases: 0 func, 1 armed, 2 sample, 3 lockout
    bit ref_st = 1'b0;
    bit ref_m  = 1'b0;
    int ref_ph = 0;

    always #2 clk = ~clk;

    muller_scan_cell u0 (
        .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b),
        .shift_en(shift_en), .shift_clk(shift_clk), .shift_in(shift_in),
        .shift_out(shift_out), .c_out(c_out)
    );

    task automatic step(input bit ta, input bit tb, input bit te, input bit tc,
                        input bit ts, input string tag);
        @(negedge clk);
        in_a = ta; in_b = tb; shift_en = te; shift_clk = tc; shift_in = ts;
        if (!te) begin
            if (ta && tb) ref_st = 1'b1;
            else if (!ta && !tb) ref_st = 1'b0;
            ref_ph = 0;
        end else begin
            case (ref_ph)
                0: ref_ph = tc ? 3 : 1;
                1: if (tc) begin ref_m = ts; ref_ph = 2; end
                2: if (tc) ref_m = ts; else begin ref_st = ~ref_m; ref_ph = 1; end
                default: if (!tc) ref_ph = 1;
            endcase
        end
        exp_q.push_back(ref_st);
        tag_q.push_back(tag);
    endtask

    // monitor: compare one expected item per edge, just after the edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            bit    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (c_out !== e || shift_out !== e) begin
                errors++;
                $display("FAIL %s: c_out=%0b shift_out=%0b expected %0b", t, c_out, shift_out, e);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        in_a = 1'b1; in_b = 1'b1;   // functional ones held during reset
        repeat (2) @(negedge clk);
        checks++;
        if (c_out !== 1'b0 || shift_out !== 1'b0) begin
            errors++;
            $display("FAIL R1: c_out=%0b shift_out=%0b expected 0", c_out, shift_out);
        end
        rst = 1'b0; in_a = 1'b0; in_b = 1'b0;
        step(0, 0, 0, 0, 0, "R1 idle after reset");

        // functional C-element behaviour
        step(1, 1, 0, 0, 0, "R2 rise");
        step(1, 0, 0, 0, 0, "R4 hold high 10");
        step(0, 1, 0, 1, 1, "R4 hold high 01 with shift clk");
        step(0, 0, 0, 0, 0, "R3 fall");
        step(1, 0, 0, 1, 0, "R4 hold low, clk pulse ignored");
        step(1, 0, 0, 0, 1, "R4 hold low, clk pulse end ignored");

        // scan enabled: functional inputs ignored
        step(1, 1, 1, 0, 0, "R5 ones ignored");
        step(1, 1, 1, 0, 0, "R5 ones ignored again");

        // full shift of a 0 -> stores 1
        step(1, 1, 1, 1, 0, "R6 hold during high");
        step(0, 0, 1, 0, 1, "R7 commit pending");
        step(0, 0, 1, 0, 1, "R7 stored inverse of 0");

        // long high phase, last sample is 1 -> stores 0
        step(0, 0, 1, 1, 0, "R6 hold high phase a");
        step(0, 0, 1, 1, 1, "R6 hold high phase b");
        step(1, 1, 1, 0, 0, "R7 commit of last sample");
        step(1, 1, 1, 0, 0, "R7 stored inverse of 1");

        // abandoned capture
        step(1, 0, 1, 1, 0, "R9 capture started");
        step(1, 0, 0, 1, 0, "R9 enable dropped");
        step(1, 0, 1, 0, 0, "R9 enable back, no commit");
        step(1, 0, 1, 0, 0, "R9 still no commit");

        // pulse already high when enable rises
        step(0, 1, 0, 1, 0, "R8 pulse with enable low");
        step(0, 1, 1, 1, 0, "R8 enable rises mid pulse");
        step(0, 1, 1, 1, 0, "R8 lockout hold");
        step(0, 1, 1, 0, 0, "R8 pulse ends, no commit");
        step(0, 1, 1, 1, 0, "R8 fresh pulse");
        step(0, 1, 1, 0, 0, "R8 fresh pulse commits");
        step(0, 1, 1, 0, 0, "R8 stored 1");

        step(0, 0, 0, 0, 0, "R3 back to function");

        for (int i = 0; i < 400; i++) begin
            bit en;
            en = ($urandom % 4) != 0;
            step(1'($urandom), 1'($urandom), en, 1'($urandom), 1'($urandom),
                 "R7 random mix");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule